// File: doc/BRIEF.md
# Wide Free-Running Counter with Snapshot Capture

This block holds a 64-bit counter that advances by one on every clock. The counter is wider than the register interface, so software never reads it directly. Instead it writes a command into a control register. The block then copies the whole counter into a pair of half-width snapshot registers in a single clock edge. Software reads the lower half and the upper half at its own pace, and both halves always belong to the same instant. A second command bit sets the counter back to zero.

A command takes effect on the clock edge after the write that carries it. Until then the command bit reads back as 1. After the action both command bits read back as 0. A clear also zeroes the snapshot pair. When one write sets both bits, the clear runs first, so the capture sees zero. The register interface is a plain write strobe with address and data. Read data is combinational from the current address.

Top module: `wide_snapshot_counter`

## Requirements
- R1: With no clear pending, the counter increases by exactly one on every clock edge after reset.
- R2: The counter wraps from all ones to zero, and the carry passes from the lower half into the upper half.
- R3: A control write with bit 1 (capture) set makes the next clock edge copy the counter's value at that edge into the snapshot pair. The lower half is read at address 1 and the upper half at address 2.
- R4: A command bit reads back as 1 in the cycle between its write and its action, and reads as 0 from then on unless it is written again.
- R5: A control write with bit 0 (clear) set makes the next clock edge set the counter to zero and both snapshot halves to zero.
- R6: When one control write sets both bits, the clear comes first and the capture stores zero.
- R7: After reset the counter, both snapshot halves and the control register (address 0) are zero.
- R8: Writes to address 1 or address 2 have no effect on the snapshot halves.
- R9: Control bits above bit 1 start no action and read as 0. Address 3 reads as 0.
- R10: With no capture and no clear, the snapshot halves keep their value over any number of cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0 control, 1 lower half, 2 upper half, 3 reserved |
| regWrData | input | HALF_W | Write data |
| regRdData | output | HALF_W | Read data for regAddr (combinational) |

## Verification
The hardest case to reach is the wrap of the full-width counter together with the carry across the half boundary. A 64-bit count never gets there in a test of reasonable length. For this reason the bench places a second copy of the block with 4-bit halves on the same stimulus. It captures that copy often enough that the captures fall on both sides of the nibble carry and of the 8-bit wrap. The one-cycle pending window of a command is reached by reading the control register in the cycle straight after the write. This includes back-to-back capture commands and a combined clear-and-capture that follows a nonzero snapshot.

// File: rtl/snapctr_pkg.sv
package snapctr_pkg;
  localparam int NUM_HALVES = 2;
  localparam int CMD_CLR_BIT = 0;
  localparam int CMD_CAP_BIT = 1;

  typedef enum logic [1:0] {
    ADDR_CTRL    = 2'd0,
    ADDR_SNAP_LO = 2'd1,
    ADDR_SNAP_HI = 2'd2,
    ADDR_RSVD    = 2'd3
  } regAddr_e;

  typedef struct packed {
    logic clrStb;
    logic capStb;
  } cmdStrobes_t;
endpackage

// File: rtl/snapctr_ctrl.sv
module snapctr_ctrl import snapctr_pkg::*; #(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [HALF_W-1:0] regWrData,
  output cmdStrobes_t       strobes,
  output logic [1:0]        pendView
);
  logic ctrlWr;
  logic pendClr, pendCap;

  assign ctrlWr = regWrEn && (regAddr == ADDR_CTRL);

  // Commands wait one edge, then act and drop
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendClr <= 1'b0;
      pendCap <= 1'b0;
    end else if (ctrlWr) begin
      pendClr <= regWrData[CMD_CLR_BIT];
      pendCap <= regWrData[CMD_CAP_BIT];
    end else begin
      pendClr <= 1'b0;
      pendCap <= 1'b0;
    end
  end

  assign strobes.clrStb = pendClr;
  assign strobes.capStb = pendCap;
  assign pendView = {pendCap, pendClr};

  assert_cap_selfclear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capStb && !ctrlWr) |=> !strobes.capStb);

  assert_clr_issue_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && regWrData[CMD_CLR_BIT]) |=> strobes.clrStb);

  assert_upper_inert_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && (regWrData[HALF_W-1:2] != '0) && (regWrData[1:0] == 2'b00))
      |=> (!strobes.clrStb && !strobes.capStb));
endmodule

// File: rtl/snapctr_datapath.sv
module snapctr_datapath import snapctr_pkg::*; #(
  parameter int HALF_W = 32
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  cmdStrobes_t                          strobes,
  output logic [NUM_HALVES-1:0][HALF_W-1:0]    snapHalves
);
  localparam int CNT_W = NUM_HALVES * HALF_W;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (strobes.clrStb) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  // Every half loads on the same edge, so the pair is one consistent value
  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               snapHalves[h] <= '0;
      else if (strobes.clrStb) snapHalves[h] <= '0;
      else if (strobes.capStb) snapHalves[h] <= cnt[h*HALF_W +: HALF_W];
    end
  end

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.clrStb |=> cnt == $past(cnt) + 1'b1);

  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((&cnt) && !strobes.clrStb) |=> cnt == '0);

  assert_capture_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capStb && !strobes.clrStb) |=> snapHalves == $past(cnt));

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrStb |=> (cnt == '0) && (snapHalves == '0));

  assert_snap_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.capStb && !strobes.clrStb) |=> $stable(snapHalves));
endmodule

// File: rtl/wide_snapshot_counter.sv
module wide_snapshot_counter import snapctr_pkg::*; #(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [HALF_W-1:0] regWrData,
  output logic [HALF_W-1:0] regRdData
);
  cmdStrobes_t                          strobes;
  logic [1:0]                           pendView;
  logic [NUM_HALVES-1:0][HALF_W-1:0]    snapHalves;

  snapctr_ctrl #(.HALF_W(HALF_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .strobes(strobes), .pendView(pendView)
  );

  snapctr_datapath #(.HALF_W(HALF_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .snapHalves(snapHalves)
  );

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_CTRL:    regRdData[1:0] = pendView;
      ADDR_SNAP_LO: regRdData = snapHalves[0];
      ADDR_SNAP_HI: regRdData = snapHalves[1];
      default:      regRdData = '0;
    endcase
  end
endmodule

// File: tb/wide_snapshot_counter_tb.sv
module wide_snapshot_counter_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] rdBig;
  logic [3:0] rdSmall;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  wide_snapshot_counter #(.HALF_W(32)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(rdBig));

  wide_snapshot_counter #(.HALF_W(4)) u_dutSmall (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData[3:0]), .regRdData(rdSmall));

  // Reference model written from the requirements
  logic [63:0] mCnt, mSnap;
  logic [7:0]  mCntS, mSnapS;
  logic [1:0]  mPend;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt <= '0; mSnap <= '0; mCntS <= '0; mSnapS <= '0; mPend <= '0;
    end else begin
      if (mPend[0]) begin
        mCnt <= '0; mSnap <= '0; mCntS <= '0; mSnapS <= '0;
      end else begin
        mCnt <= mCnt + 1'b1; mCntS <= mCntS + 1'b1;
        if (mPend[1]) begin mSnap <= mCnt; mSnapS <= mCntS; end
      end
      mPend <= (regWrEn && regAddr == 2'd0) ? regWrData[1:0] : 2'b00;
    end
  end

  typedef struct {
    logic [31:0] expBig;
    logic [3:0]  expSmall;
    string       tag;
  } item_t;
  item_t sbq[$];

  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      checks++;
      if (rdBig !== it.expBig) begin
        failures++;
        $display("FAIL %s wide: got %h expected %h", it.tag, rdBig, it.expBig);
      end
      checks++;
      if (rdSmall !== it.expSmall) begin
        failures++;
        $display("FAIL %s narrow: got %h expected %h", it.tag, rdSmall, it.expSmall);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    tick();
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rdReg(input logic [1:0] a, input string tag);
    item_t it;
    regAddr = a;
    #1;
    case (a)
      2'd0: begin it.expBig = {30'd0, mPend}; it.expSmall = {2'd0, mPend}; end
      2'd1: begin it.expBig = mSnap[31:0];  it.expSmall = mSnapS[3:0]; end
      2'd2: begin it.expBig = mSnap[63:32]; it.expSmall = mSnapS[7:4]; end
      default: begin it.expBig = '0; it.expSmall = '0; end
    endcase
    it.tag = tag;
    sbq.push_back(it);
    tick();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R7 reset state, R9 reserved address
    rdReg(2'd0, "R7"); rdReg(2'd1, "R7"); rdReg(2'd2, "R7"); rdReg(2'd3, "R9");
    idle(5);
    // R3 capture, R4 pending window then self-clear
    wrReg(2'd0, 32'h2);
    rdReg(2'd0, "R4");
    rdReg(2'd1, "R3"); rdReg(2'd2, "R3"); rdReg(2'd0, "R4");
    // R10 hold over idle cycles
    idle(9);
    rdReg(2'd1, "R10"); rdReg(2'd2, "R10");
    // R1 step between two captures
    wrReg(2'd0, 32'h2); idle(3); rdReg(2'd1, "R1");
    wrReg(2'd0, 32'h2); rdReg(2'd1, "R1");
    // R4 back-to-back capture commands
    wrReg(2'd0, 32'h2); wrReg(2'd0, 32'h2);
    rdReg(2'd0, "R4"); rdReg(2'd1, "R4"); rdReg(2'd0, "R4");
    // R5 clear zeroes counter and snapshot
    idle(4);
    wrReg(2'd0, 32'h1);
    rdReg(2'd0, "R5"); rdReg(2'd1, "R5"); rdReg(2'd2, "R5"); rdReg(2'd0, "R5");
    idle(2);
    wrReg(2'd0, 32'h2); rdReg(2'd1, "R5");
    // R6 combined command after a nonzero snapshot
    idle(6); wrReg(2'd0, 32'h2); rdReg(2'd1, "R6");
    wrReg(2'd0, 32'h3);
    rdReg(2'd0, "R6"); rdReg(2'd1, "R6"); rdReg(2'd2, "R6");
    idle(3); wrReg(2'd0, 32'h2); rdReg(2'd1, "R6");
    // R8 snapshot registers ignore writes
    wrReg(2'd1, 32'hDEAD_BEEF); wrReg(2'd2, 32'hFFFF_FFFF);
    rdReg(2'd1, "R8"); rdReg(2'd2, "R8");
    // R9 upper control bits inert
    wrReg(2'd0, 32'hFFFF_FFFC);
    rdReg(2'd0, "R9"); rdReg(2'd1, "R9"); rdReg(2'd3, "R9");
    // R2 wrap and half carry on the narrow copy
    for (int k = 0; k < 60; k++) begin
      idle(k % 7);
      wrReg(2'd0, 32'h2);
      rdReg(2'd1, "R2"); rdReg(2'd2, "R2");
    end
    idle(2);
    summary();
  end
endmodule